// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a set of level-driven interrupt request lines and one non-maskable request, and offers the CPU the single most urgent one as a vector address. Line 0 is the most urgent maskable source and each higher index is less urgent; the non-maskable line is above all of them. Every maskable line has its own enable bit, written through a small register port that can also be read back. Each source jumps to its own fixed address: a base plus the line index times a stride. The non-maskable source has an address of its own.

The controller keeps a stack of the levels now in service. When the CPU acknowledges an offer, the offered level is pushed and its pending bit is cleared. When the CPU signals return, the top level is popped. Only a request whose level is strictly more urgent than the top of the stack can be offered. This allows nesting of higher-priority service routines while same-level and lower requests wait. Reset is its own path: it drops every pending bit, enable and stack entry at once, and no save sequence is run.

The control core is a two-state machine. **ST_IDLE** means no offer is posted. Transition *post*: a qualifying candidate exists, so the machine moves to ST_OFFER. **ST_OFFER** means an offer is on `irq_valid`/`irq_vec`. Transition *take*: `cpu_ack` is seen, the level is pushed and the machine moves to ST_IDLE. Transition *withdraw*: no candidate qualifies any longer, so the machine moves to ST_IDLE. Transition *refresh*: a candidate still qualifies, so the machine stays in ST_OFFER and latches the current best.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset (rst_n low) clears all pending bits, including the non-maskable one. It also clears the enables and the service stack. During reset and afterwards, `irq_valid` is 0, `en_rdata` is 0 and `svc_level` is the idle level N_SRC+1.
- R2: A one-cycle `en_wr` loads `en_wdata` into the enable register from the next cycle on; `en_rdata` returns it. Bit i enables maskable line i, and a line whose bit is 0 is never offered.
- R3: Among the qualifying requests, the non-maskable one wins first, then the enabled pending line with the lowest index.
- R4: The offered vector is NMI_VEC for the non-maskable source and VEC_BASE + i*VEC_STRIDE for line i.
- R5: A request high at one rising edge sets a pending bit that stays set until that source is acknowledged. An acknowledge clears the bit even if the request is high in the same cycle.
- R6: With nothing in service and an enabled request driven before rising edge k, `irq_valid` is 0 after edge k and 1 after edge k+1. A `cpu_ack` while `irq_valid` is 0 has no effect.
- R7: After an accepted acknowledge, `svc_level` shows the offered level from the next cycle on. The levels are 0 for the non-maskable source, i+1 for line i, and N_SRC+1 for idle.
- R8: A source is offered only when its level is numerically below `svc_level`. Requests of equal or lower urgency stay pending and unoffered.
- R9: `cpu_ret` pops the top level and restores the level below it. A `cpu_ret` with an empty stack is ignored.
- R10: `cpu_ack` and `cpu_ret` in the same cycle replace the top level with the newly offered one, so the stack depth does not change.
- R11: The non-maskable request is offered whatever the enable register holds.
- R12: If an offered line loses its enable, `irq_valid` drops within two cycles. The offer comes back once the line is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Maskable request lines, bit 0 most urgent |
| nmi_req | input | 1 | Non-maskable request |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | N_SRC | Enable register write data |
| en_rdata | output | N_SRC | Enable register contents |
| cpu_ack | input | 1 | CPU accepts the posted offer |
| cpu_ret | input | 1 | CPU leaves the current service routine |
| irq_valid | output | 1 | An offer is posted |
| irq_vec | output | ADDR_W | Vector address of the posted offer |
| svc_level | output | clog2(N_SRC+2) | Level at the top of the service stack |

## Verification
The bench builds the block with four request lines, a 16-bit address, base 0x0100, stride 4 and non-maskable vector 0x0040. The idle level is therefore 5 and the full nesting depth of five fits a short test. With these values, three-deep nesting (line 2, then line 0, then the non-maskable source) and unwinding back to idle are quick to reach. So are a non-maskable request held off while a non-maskable routine runs, the combined acknowledge-and-return, and the release, one return at a time, of requests that were left pending under masking. A short stride keeps every vector distinct and easy to predict, so any error in the index arithmetic or in the priority order shows up as a wrong address in the scoreboard.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 4
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] en,
    input  logic             nmi_pend,
    output logic             found,
    output logic [LVL_W-1:0] lvl
);

    logic [N_SRC-1:0] live;

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_live
            assign live[gi] = pend[gi] & en[gi];
        end
    endgenerate

    // Scan from least to most urgent so the most urgent live line is kept.
    always_comb begin
        found = nmi_pend;
        lvl   = '0;
        if (!nmi_pend) begin
            for (int i = N_SRC - 1; i >= 0; i--) begin
                if (live[i]) begin
                    found = 1'b1;
                    lvl   = LVL_W'(i + 1);
                end
            end
        end
    end

endmodule

// File: rtl/level_stack.sv
module level_stack #(
    parameter int DEPTH = 9,
    parameter int LVL_W = 4,
    parameter int CNT_W = 4,
    parameter logic [LVL_W-1:0] IDLE_LVL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] push_lvl,
    output logic [LVL_W-1:0] top_lvl,
    output logic [CNT_W-1:0] cnt
);

    logic [LVL_W-1:0] stk [DEPTH];
    logic             pop_eff;

    assign pop_eff = pop && (cnt != '0);

    always_comb begin
        top_lvl = IDLE_LVL;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CNT_W'(i + 1)) top_lvl = stk[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= IDLE_LVL;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && !pop_eff && cnt == CNT_W'(i)) stk[i] <= push_lvl;
                if (push && pop_eff && cnt == CNT_W'(i + 1)) stk[i] <= push_lvl;
            end
            if (push && !pop_eff)      cnt <= cnt + 1'b1;
            else if (!push && pop_eff) cnt <= cnt - 1'b1;
        end
    end

    // R8: strict masking bounds nesting, so a growing push never meets a full stack.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_eff) |-> (cnt < CNT_W'(DEPTH)));

    // R9: a return on an empty stack leaves it empty.
    assert_empty_pop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] VEC_STRIDE = 16'h0004,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0040
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              irq_req,
    input  logic                          nmi_req,
    input  logic                          en_wr,
    input  logic [N_SRC-1:0]              en_wdata,
    output logic [N_SRC-1:0]              en_rdata,
    input  logic                          cpu_ack,
    input  logic                          cpu_ret,
    output logic                          irq_valid,
    output logic [ADDR_W-1:0]             irq_vec,
    output logic [$clog2(N_SRC+2)-1:0]    svc_level
);

    localparam int LVL_W = $clog2(N_SRC + 2);
    localparam int DEPTH = N_SRC + 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(N_SRC + 1);

    ctl_state_t       state_q, state_d;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] pend_q;
    logic             nmi_pend_q;
    logic [LVL_W-1:0] offer_lvl_q;
    logic [LVL_W-1:0] pick_lvl;
    logic             pick_found;
    logic             cand;
    logic             accept;
    logic [LVL_W-1:0] cur_lvl;
    logic [CNT_W-1:0] stk_cnt;
    logic [N_SRC-1:0] clr_line;

    prio_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_pick (
        .pend     (pend_q),
        .en       (en_q),
        .nmi_pend (nmi_pend_q),
        .found    (pick_found),
        .lvl      (pick_lvl)
    );

    level_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W), .IDLE_LVL(IDLE_LVL)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .pop      (cpu_ret),
        .push_lvl (offer_lvl_q),
        .top_lvl  (cur_lvl),
        .cnt      (stk_cnt)
    );

    assign cand   = pick_found && (pick_lvl < cur_lvl);
    assign accept = (state_q == ST_OFFER) && cpu_ack;

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_clr
            assign clr_line[gi] = accept && (offer_lvl_q == LVL_W'(gi + 1));
        end
    endgenerate

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cand) state_d = ST_OFFER;
            ST_OFFER: begin
                if (accept)     state_d = ST_IDLE;
                else if (!cand) state_d = ST_IDLE;
            end
        endcase
    end

    // State register and the data it carries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            en_q        <= '0;
            pend_q      <= '0;
            nmi_pend_q  <= 1'b0;
            offer_lvl_q <= IDLE_LVL;
        end else begin
            state_q    <= state_d;
            if (en_wr) en_q <= en_wdata;
            pend_q     <= (pend_q | irq_req) & ~clr_line;
            nmi_pend_q <= (nmi_pend_q | nmi_req) & ~(accept && offer_lvl_q == '0);
            if (!accept && cand) offer_lvl_q <= pick_lvl;
        end
    end

    // Outputs
    always_comb begin
        irq_valid = (state_q == ST_OFFER);
        en_rdata  = en_q;
        svc_level = cur_lvl;
        if (offer_lvl_q == '0)
            irq_vec = NMI_VEC;
        else
            irq_vec = VEC_BASE + ADDR_W'(offer_lvl_q - 1'b1) * VEC_STRIDE;
    end

    // R8: an accepted offer is strictly more urgent than the level in service.
    assert_accept_outranks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (offer_lvl_q < svc_level));

    // R7: the accepted level becomes the level in service.
    assert_level_follows_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (svc_level == $past(offer_lvl_q)));

    // R5: an acknowledged line's pending bit is clear on the next cycle.
    assert_ack_clears_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && offer_lvl_q != '0) |=> (pend_q[$past(offer_lvl_q) - 1'b1] == 1'b0));

    // R9: a return from a nested level restores a less urgent one.
    assert_return_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ret && !accept && stk_cnt != '0) |=> (svc_level > $past(svc_level)));

    // R11: a pending non-maskable request is posted whatever the enables hold.
    assert_nmi_posted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && nmi_pend_q && svc_level != '0) |=> (irq_valid && offer_lvl_q == '0));

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

    localparam int N = 4;
    localparam logic [15:0] BASE = 16'h0100;
    localparam logic [15:0] STRD = 16'h0004;
    localparam logic [15:0] NMIV = 16'h0040;
    localparam int IDLE = N + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic         nmi_req = 1'b0;
    logic         en_wr = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic [N-1:0] en_rdata;
    logic         cpu_ack = 1'b0;
    logic         cpu_ret = 1'b0;
    logic         irq_valid;
    logic [15:0]  irq_vec;
    logic [2:0]   svc_level;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    prio_irq_ctrl #(.N_SRC(N), .ADDR_W(16), .VEC_BASE(BASE), .VEC_STRIDE(STRD), .NMI_VEC(NMIV)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .cpu_ack(cpu_ack), .cpu_ret(cpu_ret),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .svc_level(svc_level)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] vec_of(int line);
        return BASE + 16'(line) * STRD;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
            finish_run();
        end
    end

    // Monitor: compares each accepted offer with the next expected vector.
    always @(negedge clk) begin
        #2;
        if (cpu_ack && irq_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected offer: actual=%0h expected=none", irq_vec);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (irq_vec !== e) begin
                    errors++;
                    $display("FAIL %s vector: actual=%0h expected=%0h", t, irq_vec, e);
                end
            end
        end
    end

    task automatic wcyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic [N-1:0] m, logic n);
        irq_req = m;
        nmi_req = n;
        @(negedge clk);
        irq_req = '0;
        nmi_req = 1'b0;
    endtask

    task automatic wr_en(logic [N-1:0] v);
        en_wr = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic do_ret();
        cpu_ret = 1'b1;
        @(negedge clk);
        cpu_ret = 1'b0;
    endtask

    // Driver: posts the expected vector, then acknowledges the offer.
    task automatic take(logic [15:0] v, string tag, logic with_ret);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        while (!irq_valid) @(negedge clk);
        cpu_ack = 1'b1;
        cpu_ret = with_ret;
        @(negedge clk);
        cpu_ack = 1'b0;
        cpu_ret = 1'b0;
    endtask

    initial begin
        wcyc(3);
        chk("R1 valid in reset", irq_valid, 0);
        rst_n = 1'b1;
        wcyc(1);
        chk("R1 valid", irq_valid, 0);
        chk("R1 level", svc_level, IDLE);
        chk("R1 enables", en_rdata, 0);

        // R2: disabled line is not offered
        pulse(4'b0100, 1'b0);
        wcyc(4);
        chk("R2 disabled line", irq_valid, 0);

        wr_en(4'hF);
        chk("R2 readback", en_rdata, 4'hF);
        take(vec_of(2), "R4 line2", 1'b0);
        chk("R7 level line2", svc_level, 3);

        // R8: equal and lower levels stay masked
        pulse(4'b1100, 1'b0);
        wcyc(4);
        chk("R8 equal/lower masked", irq_valid, 0);

        // R3/R8: more urgent line preempts
        pulse(4'b0001, 1'b0);
        take(vec_of(0), "R3 preempt line0", 1'b0);
        chk("R7 level line0", svc_level, 1);

        pulse(4'b0000, 1'b1);
        take(NMIV, "R3 nmi", 1'b0);
        chk("R7 level nmi", svc_level, 0);

        pulse(4'b0000, 1'b1);
        wcyc(4);
        chk("R8 nmi during nmi", irq_valid, 0);

        do_ret();
        chk("R9 restore to line0", svc_level, 1);
        take(NMIV, "R5 held nmi", 1'b0);
        do_ret();
        do_ret();
        chk("R9 restore to line2", svc_level, 3);
        wcyc(3);
        chk("R8 pending masked at line2", irq_valid, 0);
        do_ret();
        chk("R9 restore to idle", svc_level, IDLE);
        take(vec_of(2), "R5 sticky line2", 1'b0);
        do_ret();
        take(vec_of(3), "R5 sticky line3", 1'b0);
        chk("R7 level line3", svc_level, 4);
        do_ret();
        do_ret();
        chk("R9 empty return", svc_level, IDLE);
        wcyc(2);
        chk("R9 empty return no offer", irq_valid, 0);

        // R11: non-maskable ignores enables
        wr_en(4'h0);
        pulse(4'b0000, 1'b1);
        take(NMIV, "R11 nmi with enables off", 1'b0);
        do_ret();

        // R6 timing and R3 ordering
        wr_en(4'hF);
        irq_req = 4'b1010;
        @(negedge clk);
        irq_req = '0;
        chk("R6 no offer after first edge", irq_valid, 0);
        @(negedge clk);
        chk("R6 offer after second edge", irq_valid, 1);
        chk("R3 lowest index wins", irq_vec, vec_of(1));
        take(vec_of(1), "R3 line1 over line3", 1'b0);
        chk("R7 level line1", svc_level, 2);
        do_ret();
        take(vec_of(3), "R3 line3 after", 1'b0);
        do_ret();

        // R12: withdrawal on enable loss
        pulse(4'b0010, 1'b0);
        while (!irq_valid) @(negedge clk);
        wr_en(4'h0);
        chk("R2 readback cleared", en_rdata, 0);
        wcyc(1);
        chk("R12 offer withdrawn", irq_valid, 0);
        wcyc(2);
        chk("R12 stays withdrawn", irq_valid, 0);
        wr_en(4'hF);
        take(vec_of(1), "R12 offer returns", 1'b0);
        do_ret();

        // R6: stray acknowledge ignored
        wcyc(2);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R6 stray ack level", svc_level, IDLE);
        chk("R6 stray ack valid", irq_valid, 0);

        // R10: combined acknowledge and return
        pulse(4'b0100, 1'b0);
        take(vec_of(2), "R10 line2", 1'b0);
        pulse(4'b0001, 1'b0);
        take(vec_of(0), "R10 line0 with ret", 1'b1);
        chk("R10 replaced level", svc_level, 1);
        do_ret();
        chk("R10 one return to idle", svc_level, IDLE);

        // R1: reset in service
        pulse(4'b0010, 1'b0);
        take(vec_of(1), "R1 line1 before reset", 1'b0);
        pulse(4'b0000, 1'b1);
        rst_n = 1'b0;
        wcyc(2);
        chk("R1 reset level", svc_level, IDLE);
        chk("R1 reset valid", irq_valid, 0);
        chk("R1 reset enables", en_rdata, 0);
        rst_n = 1'b1;
        wcyc(4);
        chk("R1 nmi pending cleared", irq_valid, 0);

        chk("R4 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule